// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two predictors side by side and lets a per-branch chooser pick between them. The local predictor keeps a short outcome history for each branch slot. That history then selects a saturating counter. The global predictor uses a register holding the latest resolved outcomes across all branches to select a counter of its own. The chooser is a table of 2-bit counters indexed by the branch address. Its upper half selects the global answer and its lower half selects the local one.

Fetch presents a branch address and reads the prediction in the same cycle, with no register in that path. Fetch also reads the current global history and carries it along with the branch. When the branch resolves, the execution side returns the address, the real outcome and that carried history. All tables are then trained on the next clock edge. The global history register is rebuilt from the carried copy, so a wrong path cannot corrupt it.

Top module: `tbp_top`

## Requirements
- R1: After reset, every counter reads 2'b01 (weakly not-taken), every history reads zero, and every chooser entry reads 2'b01. The first prediction is therefore not-taken from both components, the local component is selected, and the global history output is 3'b000.
- R2: Table slots for both the predict port and the resolve port are selected by address bits [4:2]. Addresses that differ only outside those bits share the same local and chooser state.
- R3: Each 2-bit counter counts up on a taken outcome and down on a not-taken outcome. It saturates at 2'b00 and at 2'b11, and its MSB is the predicted direction (1 = taken).
- R4: On resolve, the local history of the addressed slot shifts left and takes the actual outcome into its LSB.
- R5: On resolve, the local pattern counter selected by that slot's pre-update history is trained toward the outcome.
- R6: On resolve, the global counter selected by the returned history snapshot is trained toward the outcome.
- R7: After a resolve, the global history output equals {snapshot[1:0], outcome}. Without a resolve, it holds its value.
- R8: The chooser slot of the resolved branch changes only when the two components disagree for that branch. In that case it counts up if the global component was right and down if the local one was right.
- R9: The final prediction equals the global component prediction when the chooser MSB is 1, and the local one otherwise. The debug outputs show both components and the selection.
- R10: Prediction is combinational from the address. A resolve in the same cycle does not affect that cycle's prediction, and its effect appears from the next cycle on.
- R11: A lone branch that alternates taken/not-taken is predicted correctly on every execution once its pattern counters are trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Final direction prediction |
| pred_local | output | 1 | Local component prediction (debug) |
| pred_global | output | 1 | Global component prediction (debug) |
| pred_use_global | output | 1 | Chooser selects the global component (debug) |
| pred_ghist | output | GHIST_W | Current global history, to be carried with the branch |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | PC_W | Address of the resolving branch |
| upd_taken | input | 1 | Actual outcome of the resolving branch |
| upd_ghist | input | GHIST_W | Global history snapshot taken at prediction |

## Verification
A prediction and a resolve can fall in the same cycle, including cases where both refer to the same table slot. The bench provokes this by driving a new fetch address and a resolve together on most cycles, often with equal addresses. Each expected prediction is computed from a model that has not yet absorbed that cycle's resolve. A prediction that reflects the update too early, or an update that is lost, therefore shows up as a mismatch in the same or the next cycle.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  // 2-bit direction counter encoding
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  // Saturating step toward the given direction
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] res;
    if (up) res = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else    res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int          IDX_W   = 3,
  parameter logic [1:0]  RST_VAL = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic [1:0]       a_ctr,
  input  logic [IDX_W-1:0] b_idx,
  output logic [1:0]       b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  import tbp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       ctr_q [DEPTH];
  logic [1:0]       ctr_d [DEPTH];
  logic [DEPTH-1:0] ctr_ce;

  // next-state
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      ctr_ce[e] = wr_en && (wr_idx == IDX_W'(e));
      ctr_d[e]  = ctr_step(ctr_q[e], wr_up);
    end
  end

  // registers
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctr_q[g] <= RST_VAL;
      else if (ctr_ce[g]) ctr_q[g] <= ctr_d[g];
    end
  end

  assign a_ctr = ctr_q[a_idx];
  assign b_ctr = ctr_q[b_idx];

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 3,
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [HIST_W-1:0] a_hist,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [HIST_W-1:0] b_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] hist_d [DEPTH];
  logic [DEPTH-1:0]  hist_ce;

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      hist_ce[e] = wr_en && (wr_idx == IDX_W'(e));
      hist_d[e]  = {hist_q[e][HIST_W-2:0], wr_bit};
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hist_q[g] <= '0;
      else if (hist_ce[g]) hist_q[g] <= hist_d[g];
    end
  end

  assign a_hist = hist_q[a_idx];
  assign b_hist = hist_q[b_idx];

endmodule

// File: rtl/tbp_local.sv
module tbp_local #(
  parameter int IDX_W  = 3,
  parameter int HIST_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pred_idx,
  output logic             pred_bit,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  output logic             res_bit
);
  logic [HIST_W-1:0] pred_hist;
  logic [HIST_W-1:0] upd_hist;
  logic [1:0]        pred_ctr;
  logic [1:0]        upd_ctr;

  tbp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (pred_idx),
    .a_hist (pred_hist),
    .b_idx  (upd_idx),
    .b_hist (upd_hist),
    .wr_en  (upd_valid),
    .wr_idx (upd_idx),
    .wr_bit (upd_taken)
  );

  tbp_ctr_table #(.IDX_W(HIST_W), .RST_VAL(2'b01)) u_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (pred_hist),
    .a_ctr  (pred_ctr),
    .b_idx  (upd_hist),
    .b_ctr  (upd_ctr),
    .wr_en  (upd_valid),
    .wr_idx (upd_hist),
    .wr_up  (upd_taken)
  );

  assign pred_bit = pred_ctr[1];
  assign res_bit  = upd_ctr[1];

endmodule

// File: rtl/tbp_global.sv
module tbp_global #(
  parameter int GHIST_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               pred_bit,
  output logic [GHIST_W-1:0] ghist,
  input  logic               upd_valid,
  input  logic [GHIST_W-1:0] upd_snap,
  input  logic               upd_taken,
  output logic               res_bit
);
  logic [GHIST_W-1:0] ghr_q;
  logic [GHIST_W-1:0] ghr_d;
  logic [1:0]         pred_ctr;
  logic [1:0]         upd_ctr;

  // next-state: rebuild from the carried snapshot
  always_comb begin
    ghr_d = ghr_q;
    if (upd_valid) ghr_d = {upd_snap[GHIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghr_q <= '0;
    else        ghr_q <= ghr_d;
  end

  tbp_ctr_table #(.IDX_W(GHIST_W), .RST_VAL(2'b01)) u_gctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (ghr_q),
    .a_ctr  (pred_ctr),
    .b_idx  (upd_snap),
    .b_ctr  (upd_ctr),
    .wr_en  (upd_valid),
    .wr_idx (upd_snap),
    .wr_up  (upd_taken)
  );

  assign ghist    = ghr_q;
  assign pred_bit = pred_ctr[1];
  assign res_bit  = upd_ctr[1];

endmodule

// File: rtl/tbp_top.sv
module tbp_top #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 3,
  parameter int HIST_W  = 3,
  parameter int GHIST_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    pred_pc,
  output logic               pred_taken,
  output logic               pred_local,
  output logic               pred_global,
  output logic               pred_use_global,
  output logic [GHIST_W-1:0] pred_ghist,
  input  logic               upd_valid,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic               upd_taken,
  input  logic [GHIST_W-1:0] upd_ghist
);
  localparam int PC_LSB = 2;
  localparam int PC_MSB = PC_LSB + IDX_W - 1;

  logic [IDX_W-1:0] pred_idx;
  logic [IDX_W-1:0] upd_idx;
  logic             loc_res;
  logic             glb_res;
  logic [1:0]       sel_ctr;
  logic [1:0]       sel_upd_ctr;
  logic             sel_wr_en;
  logic             sel_up;
  logic             unused_pc_bits;

  assign pred_idx = pred_pc[PC_MSB:PC_LSB];
  assign upd_idx  = upd_pc[PC_MSB:PC_LSB];
  assign unused_pc_bits = ^{pred_pc[PC_W-1:PC_MSB+1], pred_pc[PC_LSB-1:0],
                            upd_pc[PC_W-1:PC_MSB+1], upd_pc[PC_LSB-1:0], sel_upd_ctr};

  tbp_local #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_local (
    .clk       (clk),
    .rst_n     (rst_n),
    .pred_idx  (pred_idx),
    .pred_bit  (pred_local),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_taken (upd_taken),
    .res_bit   (loc_res)
  );

  tbp_global #(.GHIST_W(GHIST_W)) u_global (
    .clk       (clk),
    .rst_n     (rst_n),
    .pred_bit  (pred_global),
    .ghist     (pred_ghist),
    .upd_valid (upd_valid),
    .upd_snap  (upd_ghist),
    .upd_taken (upd_taken),
    .res_bit   (glb_res)
  );

  // chooser trains only on disagreement, toward the right component
  always_comb begin
    sel_wr_en = upd_valid && (loc_res != glb_res);
    sel_up    = (glb_res == upd_taken);
  end

  tbp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(2'b01)) u_chooser (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (pred_idx),
    .a_ctr  (sel_ctr),
    .b_idx  (upd_idx),
    .b_ctr  (sel_upd_ctr),
    .wr_en  (sel_wr_en),
    .wr_idx (upd_idx),
    .wr_up  (sel_up)
  );

  assign pred_use_global = sel_ctr[1];
  assign pred_taken      = pred_use_global ? pred_global : pred_local;

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    pred_pc,
  input logic               pred_taken,
  input logic               pred_local,
  input logic               pred_global,
  input logic               pred_use_global,
  input logic [GHIST_W-1:0] pred_ghist,
  input logic               upd_valid,
  input logic [PC_W-1:0]    upd_pc,
  input logic               upd_taken,
  input logic [GHIST_W-1:0] upd_ghist
);

  AST_FINAL_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken == (pred_use_global ? pred_global : pred_local)); // R9

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_ghist == {$past(upd_ghist[GHIST_W-2:0]), $past(upd_taken)}); // R7

  AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_ghist)); // R7

  AST_PRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(pred_pc) ->
      $stable({pred_taken, pred_local, pred_global, pred_use_global}))); // R10

  AST_CHOOSER_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_pc[4:2] == pred_pc[4:2]) && (upd_ghist == pred_ghist) &&
     (pred_local == pred_global))
    |=> ($stable(pred_pc) -> $stable(pred_use_global))); // R8

endmodule

bind tbp_top tbp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_tbp_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .pred_pc         (pred_pc),
  .pred_taken      (pred_taken),
  .pred_local      (pred_local),
  .pred_global     (pred_global),
  .pred_use_global (pred_use_global),
  .pred_ghist      (pred_ghist),
  .upd_valid       (upd_valid),
  .upd_pc          (upd_pc),
  .upd_taken       (upd_taken),
  .upd_ghist       (upd_ghist)
);

// File: tb/tb_tbp_top.sv
`timescale 1ns/1ps
module tb_tbp_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pred_pc;
  logic        pred_taken, pred_local, pred_global, pred_use_global;
  logic [2:0]  pred_ghist;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [2:0]  upd_ghist;

  always #2.5 clk = ~clk;

  tbp_top dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global),
    .pred_use_global(pred_use_global), .pred_ghist(pred_ghist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_ghist(upd_ghist)
  );

  typedef struct {
    logic       t, l, g, u;
    logic [2:0] gh;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference model state, built from the requirements
  logic [2:0] m_lh [8];
  logic [1:0] m_lp [8];
  logic [1:0] m_gc [8];
  logic [1:0] m_ch [8];
  logic [2:0] m_ghr;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic exp_t model_pred(input logic [31:0] pc, input string tag);
    exp_t e;
    logic [2:0] i;
    i     = pc[4:2];
    e.l   = m_lp[m_lh[i]][1];
    e.g   = m_gc[m_ghr][1];
    e.u   = m_ch[i][1];
    e.t   = e.u ? e.g : e.l;
    e.gh  = m_ghr;
    e.tag = tag;
    return e;
  endfunction

  task automatic model_upd(input logic [31:0] pc, input logic tk, input logic [2:0] snap);
    logic [2:0] i;
    logic lr, gr;
    i  = pc[4:2];
    lr = m_lp[m_lh[i]][1];
    gr = m_gc[snap][1];
    if (lr != gr) m_ch[i] = sat(m_ch[i], gr == tk);
    m_lp[m_lh[i]] = sat(m_lp[m_lh[i]], tk);
    m_lh[i] = {m_lh[i][1:0], tk};
    m_gc[snap] = sat(m_gc[snap], tk);
    m_ghr = {snap[1:0], tk};
  endtask

  // driver: one cycle of predict plus optional resolve
  task automatic step(input logic [31:0] ppc, input logic uv, input logic [31:0] upc,
                      input logic tk, input string tag);
    @(negedge clk);
    pred_pc   = ppc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_taken = tk;
    upd_ghist = m_ghr;
    #1;
    sb_q.push_back(model_pred(ppc, tag));
    if (uv) model_upd(upc, tk, m_ghr);
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() != 0);
      e = sb_q.pop_front();
      n_cmp++;
      if ({pred_taken, pred_local, pred_global, pred_use_global, pred_ghist} !==
          {e.t, e.l, e.g, e.u, e.gh}) begin
        n_bad++;
        $display("FAIL %s: got t/l/g/u/gh=%b%b%b%b/%b expected %b%b%b%b/%b", e.tag,
                 pred_taken, pred_local, pred_global, pred_use_global, pred_ghist,
                 e.t, e.l, e.g, e.u, e.gh);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pred_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_ghist = '0;
    for (int i = 0; i < 8; i++) begin
      m_lh[i] = 3'b000; m_lp[i] = 2'b01; m_gc[i] = 2'b01; m_ch[i] = 2'b01;
    end
    m_ghr = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen at the ports
    step(32'h100, 1'b0, 32'h0, 1'b0, "R1 reset");
    step(32'h11C, 1'b0, 32'h0, 1'b0, "R1 reset");

    // R3 R5 R6 R10: saturate upward with same-cycle predict and resolve
    for (int k = 0; k < 5; k++) step(32'h108, 1'b1, 32'h108, 1'b1, "R3 R10 sat up");
    step(32'h108, 1'b1, 32'h108, 1'b0, "R3 R5 one down");
    step(32'h108, 1'b0, 32'h0, 1'b0, "R3 R6 after down");
    for (int k = 0; k < 6; k++) step(32'h108, 1'b1, 32'h108, 1'b0, "R3 sat down");

    // R2: aliasing on bits [4:2]
    step(32'h128, 1'b0, 32'h0, 1'b0, "R2 alias");
    step(32'hFFFF_FF08, 1'b0, 32'h0, 1'b0, "R2 alias high");
    step(32'h10C, 1'b1, 32'h12C, 1'b1, "R2 R4 alias update");
    step(32'h10C, 1'b0, 32'h0, 1'b0, "R2 R4 alias read");

    // R7: history holds when idle
    step(32'h100, 1'b0, 32'h0, 1'b0, "R7 hold");
    step(32'h100, 1'b0, 32'h0, 1'b0, "R7 hold");

    // R11: alternating branch
    for (int k = 0; k < 24; k++) begin
      logic tk;
      tk = k[0];
      step(32'h114, 1'b1, 32'h114, tk, "R11 R4 R5 alternating");
      if (k >= 12) begin
        n_cmp++;
        if (pred_taken !== tk) begin
          n_bad++;
          $display("FAIL R11: got %b expected %b", pred_taken, tk);
        end
      end
    end

    // R8 R9: mixed traffic provoking chooser movement
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      logic tk;
      a  = 32'h100 + {$urandom_range(0, 7), 2'b00};
      b  = (k % 3 == 0) ? a : 32'h100 + {$urandom_range(0, 7), 2'b00};
      tk = ($urandom_range(0, 3) != 0) ^ b[3];
      step(a, ($urandom_range(0, 4) != 0), b, tk, "R8 R9 R6 R7 mixed");
    end

    @(negedge clk);
    #1;
    wait (sb_q.size() == 0);
    finish_run();
  end

endmodule